// File: doc/BRIEF.md
# Packed-share rotating refresh unit

This unit re-randomises a packed share word in which every d-bit chunk carries all the shares of one masked bit. A round draws one random word `r`, builds the vector `r ^ rot1(r)`, and XORs it into the state. `rot1` rotates each chunk by one place. Inside every chunk each bit of `r` appears exactly twice, so the XOR of the chunk's shares, and with it the masked bit, stays the same. The shares themselves become fresh.

A single start pulse loads the word. The unit then runs a fixed number of rounds in sequence. It asks for one random word per round and waits through any cycles in which the source has no word ready. When the last round is absorbed it raises a one-cycle completion pulse and holds the result until the next start. The round count follows from the share count d at elaboration. A share count equal to the word width selects a plain full-word rotate. Smaller powers of two select the per-chunk rotation.

Top module: `prf_refresh`

## Requirements
- R1: After reset `word_o`, `done_o`, `busy_o` and `rnd_req_o` are all 0.
- R2: A `start_i` pulse seen while `busy_o` is 0 loads `word_i` into the state at that clock edge. From the next cycle `word_o` equals `word_i`, `busy_o` is 1, and `rnd_req_o` equals `busy_o`.
- R3: At every edge where `rnd_req_o` and `rnd_ack_i` are both 1, the state becomes `state ^ rnd_i ^ rot1(rnd_i)`. Bits are numbered from the chunk LSB, chunks are the aligned d-bit fields of the word, and in `rot1` output bit j of a chunk takes input bit j-1, with bit 0 taking bit d-1.
- R4: One refresh takes exactly max(1, ceil((d-1)/3)) accepted random words: 1 for d=2, 3 for d=8 and 11 for d=32.
- R5: `rnd_ack_i` and `rnd_i` have no effect while `busy_o` is 0.
- R6: In a busy cycle with `rnd_ack_i` at 0 the state and the round progress stay unchanged.
- R7: `done_o` is 1 for exactly one cycle, the cycle that follows the edge accepting the final random word. In that same cycle `busy_o` is already 0.
- R8: After completion `word_o` holds the final value until the next accepted start.
- R9: `start_i` is ignored while `busy_o` is 1.
- R10: The XOR of the d bits in every chunk of the state is unchanged by each round and by the whole refresh.
- R11: With d equal to the 32-bit word width, the whole word forms one chunk and the rotation is a full-word rotate by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load pulse for a new word |
| word_i | input | WORD_W | Packed shares to refresh |
| rnd_req_o | output | 1 | Random word wanted |
| rnd_ack_i | input | 1 | Random word present on `rnd_i` |
| rnd_i | input | WORD_W | Random word |
| word_o | output | WORD_W | Current or final refreshed word |
| busy_o | output | 1 | Refresh in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds three copies side by side with d = 2, 8 and 32. All three receive the same start and random stream, so one stimulus exercises the single-round minimum, a three-round masked chunk rotation and the eleven-round full-word variant. Because the copies finish at different points in one shared random sequence, each copy's completion pulse, held result and ignored late acknowledges can be checked against copies that are still running. Gaps in the acknowledge pattern and a start issued during the first round reach the wait and ignore paths.

// File: rtl/prf_pkg.sv
package prf_pkg;

   // Rounds needed for a share count: ceil((d-1)/3), never below one.
   function automatic int rounds_for(input int share_n);
      int r;
      r = (share_n + 1) / 3;
      if (r < 1) r = 1;
      return r;
   endfunction

endpackage

// File: rtl/prf_chunk_rot.sv
module prf_chunk_rot #(
   parameter int WORD_W  = 32,
   parameter int SHARE_N = 8
) (
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] dout
);
   localparam int CHUNKS = WORD_W / SHARE_N;

   generate
      if (SHARE_N == WORD_W) begin : g_full
         assign dout = {din[WORD_W-2:0], din[WORD_W-1]};
      end else begin : g_chunked
         for (genvar g = 0; g < CHUNKS; g++) begin : g_chunk
            assign dout[g*SHARE_N +: SHARE_N] =
               {din[g*SHARE_N +: SHARE_N-1], din[g*SHARE_N + SHARE_N - 1]};
         end
      end
   endgenerate
endmodule

// File: rtl/prf_round_seq.sv
module prf_round_seq #(
   parameter int ROUNDS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic ack_i,
   output logic busy_o,
   output logic load_o,
   output logic step_o,
   output logic done_o
);
   localparam int CW = $clog2(ROUNDS + 1);

   logic [CW-1:0] cnt_q;
   logic          last;

   assign load_o = start_i && !busy_o;
   assign step_o = busy_o && ack_i;
   assign last   = step_o && (cnt_q == CW'(ROUNDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         cnt_q  <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= last;
         if (load_o) begin
            busy_o <= 1'b1;
            cnt_q  <= '0;
         end else if (step_o) begin
            cnt_q <= cnt_q + 1'b1;
            if (last) busy_o <= 1'b0;
         end
      end
   end

   // R4: progress never passes the configured round count
   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (cnt_q < CW'(ROUNDS)));
   // R7: completion is a single-cycle pulse with the unit already idle
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   // R9: a start during a run does not restart the count
   p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !ack_i) |=> $stable(cnt_q));
endmodule

// File: rtl/prf_refresh.sv
module prf_refresh #(
   parameter int WORD_W  = 32,
   parameter int SHARE_N = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              rnd_req_o,
   input  logic              rnd_ack_i,
   input  logic [WORD_W-1:0] rnd_i,
   output logic [WORD_W-1:0] word_o,
   output logic              busy_o,
   output logic              done_o
);
   localparam int CHUNKS = WORD_W / SHARE_N;
   localparam int ROUNDS = prf_pkg::rounds_for(SHARE_N);

   generate
      if (SHARE_N < 2 || SHARE_N > WORD_W) begin : g_bad_range
         $error("prf_refresh: SHARE_N out of range");
      end
      if ((SHARE_N & (SHARE_N - 1)) != 0 || (WORD_W % SHARE_N) != 0) begin : g_bad_div
         $error("prf_refresh: SHARE_N must be a power of two dividing WORD_W");
      end
   endgenerate

   logic [WORD_W-1:0] state_q;
   logic [WORD_W-1:0] rnd_rot;
   logic [CHUNKS-1:0] par;
   logic              load, step;

   prf_round_seq #(.ROUNDS(ROUNDS)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .ack_i   (rnd_ack_i),
      .busy_o  (busy_o),
      .load_o  (load),
      .step_o  (step),
      .done_o  (done_o)
   );

   prf_chunk_rot #(.WORD_W(WORD_W), .SHARE_N(SHARE_N)) u_rot (
      .din  (rnd_i),
      .dout (rnd_rot)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    state_q <= '0;
      else if (load) state_q <= word_i;
      else if (step) state_q <= state_q ^ rnd_i ^ rnd_rot;
   end

   assign word_o    = state_q;
   assign rnd_req_o = busy_o;

   for (genvar g = 0; g < CHUNKS; g++) begin : g_par
      assign par[g] = ^state_q[g*SHARE_N +: SHARE_N];
   end

   // R10: every absorbed round keeps each chunk's parity
   p_parity_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (par == $past(par)));
   // R6: a busy cycle without a random word leaves the state alone
   p_wait_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !rnd_ack_i) |=> $stable(word_o));
   // R5, R8: while idle with no start the output is held whatever the ack does
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(word_o));
   // R2: an accepted start shows the loaded word next cycle
   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && word_o == $past(word_i)));
endmodule

// File: tb/prf_refresh_tb.sv
module prf_refresh_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        ack = 1'b0;
   logic [31:0] win = '0;
   logic [31:0] rnd = '0;
   logic [31:0] w2, w8, w32;
   logic        q2, q8, q32, b2, b8, b32, d2, d8, d32;
   int          nvec = 0;
   int          nbad = 0;
   logic [31:0] seed = 32'h1234_5678;

   always #2 clk = ~clk;

   prf_refresh #(.WORD_W(32), .SHARE_N(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .word_i(win), .rnd_req_o(q8),
      .rnd_ack_i(ack), .rnd_i(rnd), .word_o(w8), .busy_o(b8), .done_o(d8));
   prf_refresh #(.WORD_W(32), .SHARE_N(2)) u_dut_n2 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .word_i(win), .rnd_req_o(q2),
      .rnd_ack_i(ack), .rnd_i(rnd), .word_o(w2), .busy_o(b2), .done_o(d2));
   prf_refresh #(.WORD_W(32), .SHARE_N(32)) u_dut_w32 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .word_i(win), .rnd_req_o(q32),
      .rnd_ack_i(ack), .rnd_i(rnd), .word_o(w32), .busy_o(b32), .done_o(d32));

   function automatic logic [31:0] brot(input logic [31:0] x, input int d);
      logic [31:0] y;
      for (int j = 0; j < 32; j++) y[j] = x[(j / d) * d + ((j % d) + d - 1) % d];
      return y;
   endfunction

   function automatic logic [31:0] bpar(input logic [31:0] x, input int d);
      logic [31:0] p = '0;
      for (int j = 0; j < 32; j++) p[j / d] = p[j / d] ^ x[j];
      return p;
   endfunction

   function automatic logic [31:0] next_rnd();
      seed = seed * 32'd1664525 + 32'd1013904223;
      return seed;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 word d8", w8, 32'h0);
      chk("R1 flags d8", {q8, b8, d8}, 32'h0);
      chk("R1 flags d2", {q2, b2, d2}, 32'h0);
      chk("R1 flags d32", {q32, b32, d32}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // One full refresh on all three copies with an acknowledge gap pattern.
   task automatic t_refresh(input string name, input logic [31:0] word,
                            input logic [7:0] gaps, input bit mid_start);
      logic [31:0] e2 = word, e8 = word, e32 = word;
      int cnt = 0;
      win = word; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk({"R2 load ", name}, w8, word);
      chk({"R2 busy/req ", name}, {b2, b8, b32, q2, q8, q32}, 32'h3f);
      for (int cyc = 0; cnt < 11; cyc++) begin
         ack = gaps[cyc % 8] || (mid_start && cyc == 0);
         rnd = next_rnd();
         if (mid_start && cyc == 0) begin
            start = 1'b1; win = ~word;  // R9: must be ignored
         end
         @(negedge clk);
         start = 1'b0;
         if (ack) begin
            cnt++;
            if (cnt <= 1)  e2  = e2  ^ rnd ^ brot(rnd, 2);
            if (cnt <= 3)  e8  = e8  ^ rnd ^ brot(rnd, 8);
            if (cnt <= 11) e32 = e32 ^ rnd ^ brot(rnd, 32);
         end
         chk({"R3/R6/R9 d2 ", name}, w2, e2);
         chk({"R3/R6/R9 d8 ", name}, w8, e8);
         chk({"R3/R11 d32 ", name}, w32, e32);
         chk({"R4/R7 done ", name}, {d2, d8, d32},
             {29'd0, ack && cnt == 1, ack && cnt == 3, ack && cnt == 11});
         chk({"R4/R7 busy ", name}, {b2, b8, b32}, {29'd0, cnt < 1, cnt < 3, cnt < 11});
      end
      ack = 1'b0;
      chk({"R10 parity d2 ", name}, bpar(w2, 2), bpar(word, 2));
      chk({"R10 parity d8 ", name}, bpar(w8, 8), bpar(word, 8));
      chk({"R10 parity d32 ", name}, bpar(w32, 32), bpar(word, 32));
      // R5, R8: idle acknowledges with fresh words change nothing
      for (int k = 0; k < 3; k++) begin
         ack = 1'b1; rnd = next_rnd();
         @(negedge clk);
         chk({"R5/R8 hold ", name}, w8 ^ w2 ^ w32, e8 ^ e2 ^ e32);
         chk({"R7 no repeat ", name}, {d2, d8, d32, b2, b8, b32}, 32'h0);
      end
      ack = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      t_reset();
      t_refresh("solid", 32'hDEAD_BEEF, 8'hff, 1'b0);
      t_refresh("gaps", 32'h0F0F_1234, 8'b1011_0101, 1'b0);
      t_refresh("midstart", 32'h8000_0001, 8'b0110_1101, 1'b1);
      t_refresh("zero", 32'h0000_0000, 8'b1000_0001, 1'b0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule